// File: doc/BRIEF.md
# Latency-Insensitive Register Node

This block wraps a single data register so that it behaves as a node in a network of bounded FIFOs. The network may insert any delay on the node's input or output channel. Each word the node hands to its output FIFO stands for one clock tick of a plain synchronous register. The value that the register takes for the next tick is fetched later from the input FIFO. Between the two steps, a done flag records that the output for the current tick has already been sent.

The output step depends only on space in the output FIFO and never waits for an input token. The node therefore keeps making progress when it sits in a feedback loop, even a loop whose FIFOs hold a single entry. After it has emitted a tick's value, the node always consumes exactly one input token, so tokens never pile up on its input.

Top module: `li_reg_node`

## Requirements
- R1: After reset the register holds `INIT_VAL` on `out_data`, and `in_deq` stays low even when the input FIFO is not empty, because no output has been sent yet.
- R2: When no output has been sent for the current tick and `out_full` is low, `out_enq` is high in that cycle whatever the state of `in_empty`. In particular, `out_enq` is high in the cycle after every load, unless the output FIFO is full.
- R3: `out_enq` is never high while `out_full` is high.
- R4: After an `out_enq` pulse, no further `out_enq` occurs and `out_data` holds its value until an input token has been loaded.
- R5: After output has been sent, `in_deq` goes high in any cycle in which `in_empty` is low. In the next cycle `out_data` equals the `in_data` value that was present on that dequeue.
- R6: `in_deq` is never high while `in_empty` is high.
- R7: `out_enq` and `in_deq` are never high in the same cycle.
- R8: The nth value taken from the output FIFO equals the nth output of a synchronous register that starts at `INIT_VAL` and receives the same input sequence. This holds with random stalls, and it holds in a loop through depth-1 FIFOs.
- R9: The data width is the parameter `DATA_W`. Both strobes are single-cycle pulses: neither is high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_empty | input | 1 | Input FIFO has no token |
| in_data | input | DATA_W | Head word of the input FIFO |
| in_deq | output | 1 | Dequeue strobe to the input FIFO |
| out_full | input | 1 | Output FIFO has no space |
| out_data | output | DATA_W | Word written to the output FIFO (current register value) |
| out_enq | output | 1 | Enqueue strobe to the output FIFO |

## Verification
The assertions check the per-cycle handshake rules on every cycle:
- no strobe into a full or empty FIFO;
- the two steps never fire together;
- strobes last one cycle;
- the register holds between emit and load;
- the loaded value appears on the next cycle;
- an emit follows a load as soon as there is space.

Only the bench's scenarios can show the history-level properties. These are the match of the whole output stream against a synchronous register under random stalls, and freedom from deadlock when the output is fed back through one-entry FIFOs.

// File: rtl/li_reg_pkg.sv
package li_reg_pkg;

  // Output step is allowed: tick value not yet sent and room downstream.
  function automatic logic may_emit(input logic sent, input logic dn_full);
    return !sent && !dn_full;
  endfunction

  // Load step is allowed: tick value sent and a token is waiting.
  function automatic logic may_load(input logic sent, input logic up_empty);
    return sent && !up_empty;
  endfunction

endpackage

// File: rtl/li_reg_phase.sv
module li_reg_phase
  import li_reg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic up_empty,
  input  logic dn_full,
  output logic fire_emit,
  output logic fire_load,
  output logic sent_q
);

  assign fire_emit = may_emit(sent_q, dn_full);
  assign fire_load = may_load(sent_q, up_empty);

  always_ff @(posedge clk) begin
    if (!rst_n)         sent_q <= 1'b0;
    else if (fire_emit) sent_q <= 1'b1;
    else if (fire_load) sent_q <= 1'b0;
  end

endmodule

// File: rtl/li_reg_hold.sv
module li_reg_hold #(
  parameter int              DATA_W   = 16,
  parameter logic [DATA_W-1:0] INIT_VAL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);

  always_ff @(posedge clk) begin
    if (!rst_n)    q <= INIT_VAL;
    else if (load) q <= d;
  end

endmodule

// File: rtl/li_reg_node.sv
module li_reg_node #(
  parameter int                DATA_W   = 16,
  parameter logic [DATA_W-1:0] INIT_VAL = 16'h00A5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_empty,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_deq,
  input  logic              out_full,
  output logic [DATA_W-1:0] out_data,
  output logic              out_enq
);

  // Internal events brought out by name for the checker.
  logic fire_emit;
  logic fire_load;
  logic sent_q;

  li_reg_phase u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_empty (in_empty),
    .dn_full  (out_full),
    .fire_emit(fire_emit),
    .fire_load(fire_load),
    .sent_q   (sent_q)
  );

  li_reg_hold #(.DATA_W(DATA_W), .INIT_VAL(INIT_VAL)) u_hold (
    .clk  (clk),
    .rst_n(rst_n),
    .load (fire_load),
    .d    (in_data),
    .q    (out_data)
  );

  assign out_enq = fire_emit;
  assign in_deq  = fire_load;

endmodule

// File: rtl/li_reg_node_chk.sv
module li_reg_node_chk #(
  parameter int                DATA_W   = 16,
  parameter logic [DATA_W-1:0] INIT_VAL = '0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_empty,
  input logic [DATA_W-1:0] in_data,
  input logic              in_deq,
  input logic              out_full,
  input logic [DATA_W-1:0] out_data,
  input logic              out_enq,
  input logic              sent_q
);

  p_no_emit_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_full |-> !out_enq);

  p_no_load_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_empty |-> !in_deq);

  p_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_enq && in_deq));

  p_one_emit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_enq |=> !out_enq);

  p_hold_after_emit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_enq |=> $stable(out_data));

  p_load_value_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_deq |=> (out_data == $past(in_data)));

  p_emit_after_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_deq |=> (out_full || out_enq));

  p_load_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_deq |=> !in_deq);

  p_load_only_when_sent_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_deq |-> sent_q);

endmodule

bind li_reg_node li_reg_node_chk #(.DATA_W(DATA_W), .INIT_VAL(INIT_VAL)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .in_empty(in_empty),
  .in_data (in_data),
  .in_deq  (in_deq),
  .out_full(out_full),
  .out_data(out_data),
  .out_enq (out_enq),
  .sent_q  (sent_q)
);

// File: tb/li_reg_node_bench.sv
module li_reg_node_bench;
  localparam int           W    = 16;
  localparam logic [W-1:0] INIT = 16'h00A5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // 0 directed, 1 open channel, 2 feedback loop
  int mode = 0;
  logic         d_empty = 1'b1, d_full = 1'b1;
  logic [W-1:0] d_data = '0;

  // one-entry FIFO models
  logic         if_v, of_v;
  logic [W-1:0] if_d, of_d;
  logic         push_req = 1'b0;
  logic [W-1:0] push_val = '0;
  logic         pop_req = 1'b0;

  logic         in_empty, out_full, in_deq, out_enq;
  logic [W-1:0] in_data, out_data;

  assign in_empty = (mode == 0) ? d_empty : !if_v;
  assign in_data  = (mode == 0) ? d_data  : if_d;
  assign out_full = (mode == 0) ? d_full  : of_v;

  li_reg_node #(.DATA_W(W), .INIT_VAL(INIT)) u_li_reg_node (
    .clk(clk), .rst_n(rst_n),
    .in_empty(in_empty), .in_data(in_data), .in_deq(in_deq),
    .out_full(out_full), .out_data(out_data), .out_enq(out_enq)
  );

  wire pop_now  = pop_req && of_v;
  wire loop_psh = (mode == 2) && pop_now;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      if_v <= 1'b0; of_v <= 1'b0; if_d <= '0; of_d <= '0;
    end else begin
      if (in_deq) if_v <= 1'b0;
      if (loop_psh) begin if_v <= 1'b1; if_d <= of_d + 16'd1; end
      else if (mode == 1 && push_req && !if_v) begin if_v <= 1'b1; if_d <= push_val; end
      if (pop_now) of_v <= 1'b0;
      if (out_enq) begin of_v <= 1'b1; of_d <= out_data; end
    end
  end

  // scoreboard
  logic [W-1:0] exp_q[$];

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (rst_n && mode != 0 && pop_now) begin
      if (exp_q.size() == 0) chk("R8 extra output", of_d, '1);
      else chk("R8 stream", of_d, exp_q.pop_front());
    end
  end

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic drain_wait(input string req);
    int t = 0;
    while (exp_q.size() != 0 && t < 5000) begin @(negedge clk); t++; end
    if (exp_q.size() != 0) chk(req, W'(exp_q.size()), '0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // ---- directed ----
    mode = 0;
    do_reset();
    d_full = 1'b1; d_empty = 1'b0; d_data = 16'h1111;
    #1;
    chk("R1 init value", out_data, INIT);
    chk("R1 no load before emit", {15'b0, in_deq}, 16'd0);
    chk("R3 no emit when full", {15'b0, out_enq}, 16'd0);
    @(negedge clk);
    d_full = 1'b0; d_empty = 1'b1; #1;
    chk("R2 emit without input", {15'b0, out_enq}, 16'd1);
    @(negedge clk); #1;
    chk("R4 single emit", {15'b0, out_enq}, 16'd0);
    chk("R6 no load when empty", {15'b0, in_deq}, 16'd0);
    chk("R4 value held", out_data, INIT);
    d_empty = 1'b0; d_data = 16'h1234; #1;
    chk("R5 load strobe", {15'b0, in_deq}, 16'd1);
    chk("R7 exclusive", {15'b0, out_enq}, 16'd0);
    @(negedge clk); #1;
    chk("R5 loaded value", out_data, 16'h1234);
    chk("R9 load pulse", {15'b0, in_deq}, 16'd0);
    chk("R2 emit after load", {15'b0, out_enq}, 16'd1);
    d_full = 1'b1; #1;
    chk("R3 full blocks emit", {15'b0, out_enq}, 16'd0);

    // ---- open channel with random stalls ----
    d_full = 1'b1; d_empty = 1'b1;
    do_reset();
    exp_q.delete();
    exp_q.push_back(INIT);
    mode = 1;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      pop_req = ($urandom_range(0, 2) != 0);
      push_req = 1'b0;
      if (!if_v && $urandom_range(0, 1) == 1) begin
        push_req = 1'b1;
        push_val = W'($urandom);
        exp_q.push_back(push_val);
      end
    end
    @(negedge clk); push_req = 1'b0; pop_req = 1'b1;
    drain_wait("R8 open drain");

    // ---- feedback loop through depth-1 FIFOs ----
    mode = 0; pop_req = 1'b0;
    do_reset();
    exp_q.delete();
    for (int k = 0; k < 400; k++) exp_q.push_back(INIT + W'(k));
    mode = 2;
    for (int k = 0; k < 3000 && exp_q.size() != 0; k++) begin
      @(negedge clk);
      pop_req = ($urandom_range(0, 3) != 0) && !if_v;
    end
    drain_wait("R8 loop progress");
    mode = 0; pop_req = 1'b0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule